// File: doc/BRIEF.md
# Chip-Select Channel with Interrupt-Acknowledge Matching

This block is one programmable chip-select channel for a processor bus. For each bus cycle it decides whether its strobe should fire. It compares the cycle's address space and privilege state with the space selected in its option register. In CPU space the channel stops decoding ordinary accesses. It then reacts only to interrupt-acknowledge cycles, and it compares the priority level being acknowledged, which appears on address bits [3:1], with a programmed level. This lets the strobe act as the acknowledge line of one external peripheral.

On a matching acknowledge cycle the channel can also return an autovector request itself, which ends the acknowledge cycle without a vector from the device. The bus master marks a cycle with a start pulse and an end pulse. Option writes are deferred while a cycle is open, so the decode never changes under a running cycle.

Top module: `cs_iack_matcher`

## Requirements
- R1: `opt_wdata_i` packs the options as [6] channel enable, [5:4] space, [3:1] priority level, [0] autovector enable. A write while no cycle is open takes effect at that clock edge, so a cycle started on the next edge is decoded with it.
- R2: Space 01 (user) asserts the strobe only for cycles with `cyc_cpu_i` low and `cyc_super_i` low.
- R3: Space 10 (supervisor) asserts the strobe only for cycles with `cyc_cpu_i` low and `cyc_super_i` high.
- R4: Space 11 asserts the strobe for any cycle with `cyc_cpu_i` low, whatever the state of `cyc_super_i`.
- R5: Space 00 (CPU) asserts the strobe only for cycles with `cyc_cpu_i` high, and only when `addr_i[3:1]` equals the level field. `addr_i[0]` plays no part.
- R6: In space 00, a level field of 000 matches an acknowledge cycle of any level.
- R7: `cs_no` goes low in the cycle after the edge that samples a qualified `cyc_start_i`. It stays low until the edge that samples `cyc_end_i`, and is high after that edge. A start pulse while a cycle is already open is ignored.
- R8: With space 00 and autovector enable 1, a matching cycle raises `avec_o` for exactly one clock, in the first clock that `cs_no` is low.
- R9: With space 00 and autovector enable 0, `avec_o` stays low even when the strobe fires.
- R10: The autovector enable bit has no effect when the space is not 00: `avec_o` stays low.
- R11: With the channel enable bit clear, `cs_no` stays high and `avec_o` stays low for every cycle.
- R12: A write that arrives while a cycle is open is held. It takes effect at the first edge at which no cycle is open. A cycle starting on that same edge is still decoded with the previous options. When several writes are held, the last one wins.
- R13: After reset, `cs_no` is high, `avec_o` is low and the options are all zero, which leaves the channel disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opt_wr_i | input | 1 | Option register write strobe |
| opt_wdata_i | input | 7 | Option write data (enable, space, level, autovector enable) |
| cyc_start_i | input | 1 | Bus cycle start pulse |
| cyc_end_i | input | 1 | Bus cycle end pulse |
| cyc_cpu_i | input | 1 | Current cycle is a CPU-space (interrupt-acknowledge) cycle |
| cyc_super_i | input | 1 | Current cycle runs in supervisor state |
| addr_i | input | ADDR_W (24) | Address lines; bits [3:1] carry the acknowledged level |
| cs_no | output | 1 | Chip-select strobe, active low |
| avec_o | output | 1 | Autovector request pulse, active high |

## Verification
The strobe and the autovector pulse are both registered from the start edge, so both are due one clock after `cyc_start_i` is sampled. The release of the strobe is due one clock after `cyc_end_i` is sampled. The bench drives every input at a falling edge and samples at the next falling edge, which always places the sample half a period after the edge that should have produced the result. A write made while idle is checked by starting a cycle on the very next edge. A write held during a cycle is checked twice: with a cycle started on the release edge, which must still see the old options, and with a cycle started one clock later, which must see the new ones.

// File: rtl/cs_iack_pkg.sv
package cs_iack_pkg;

  localparam int LVL_W   = 3;
  localparam int LVL_LSB = 1;

  typedef enum logic [1:0] {
    SP_CPU  = 2'b00,
    SP_USER = 2'b01,
    SP_SUPV = 2'b10,
    SP_ANY  = 2'b11
  } space_e;

  // bit order is the software-visible write layout
  typedef struct packed {
    logic             en;
    space_e           space;
    logic [LVL_W-1:0] lvl;
    logic             avec_en;
  } cs_opt_t;

  localparam int OPT_W = $bits(cs_opt_t);

endpackage

// File: rtl/cs_opt_reg.sv
module cs_opt_reg
  import cs_iack_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_i,
  input  cs_opt_t wdata_i,
  input  logic    busy_i,
  output cs_opt_t opt_o
);

  cs_opt_t opt_q;
  cs_opt_t pend_q;
  logic    pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opt_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else if (!busy_i) begin
      // a fresh idle write supersedes anything held
      if (wr_i)            opt_q <= wdata_i;
      else if (pend_vld_q) opt_q <= pend_q;
      pend_vld_q <= 1'b0;
    end else if (wr_i) begin
      pend_q     <= wdata_i;
      pend_vld_q <= 1'b1;
    end
  end

  assign opt_o = opt_q;

  assert_opt_frozen_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(opt_q));

  assert_idle_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && wr_i) |=> (opt_q == $past(wdata_i)));

endmodule

// File: rtl/cs_match.sv
module cs_match
  import cs_iack_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  cs_opt_t           opt_i,
  input  logic              cpu_i,
  input  logic              super_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              avec_req_o
);

  logic [LVL_W-1:0] lvl_seen;
  logic             lvl_ok;
  logic             space_ok;
  logic             unused_addr;

  assign lvl_seen    = addr_i[LVL_LSB +: LVL_W];
  assign unused_addr = ^{addr_i[ADDR_W-1:LVL_LSB+LVL_W], addr_i[LVL_LSB-1:0]};

  // level 0 acts as a wildcard
  assign lvl_ok = (opt_i.lvl == '0) || (lvl_seen == opt_i.lvl);

  always_comb begin
    unique case (opt_i.space)
      SP_CPU:  space_ok = cpu_i && lvl_ok;
      SP_USER: space_ok = !cpu_i && !super_i;
      SP_SUPV: space_ok = !cpu_i && super_i;
      SP_ANY:  space_ok = !cpu_i;
      default: space_ok = 1'b0;
    endcase
  end

  assign hit_o      = opt_i.en && space_ok;
  assign avec_req_o = (opt_i.space == SP_CPU) && opt_i.avec_en;

endmodule

// File: rtl/cs_strobe_fsm.sv
module cs_strobe_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic end_i,
  input  logic hit_i,
  input  logic avec_req_i,
  output logic cs_no,
  output logic avec_o,
  output logic busy_o
);

  logic cyc_q;
  logic cs_q;
  logic avec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= 1'b0;
      cs_q   <= 1'b0;
      avec_q <= 1'b0;
    end else if (!cyc_q) begin
      avec_q <= 1'b0;
      if (start_i) begin
        cyc_q  <= 1'b1;
        cs_q   <= hit_i;
        avec_q <= hit_i && avec_req_i;
      end
    end else begin
      avec_q <= 1'b0;
      if (end_i) begin
        cyc_q <= 1'b0;
        cs_q  <= 1'b0;
      end
    end
  end

  assign cs_no  = !cs_q;
  assign avec_o = avec_q;
  assign busy_o = cyc_q;

  assert_cs_after_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(start_i));

  assert_cs_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && end_i) |=> cs_no);

  assert_avec_in_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avec_o |-> !cs_no);

  assert_avec_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avec_o |=> !avec_o);

endmodule

// File: rtl/cs_iack_matcher.sv
module cs_iack_matcher
  import cs_iack_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              opt_wr_i,
  input  logic [OPT_W-1:0]  opt_wdata_i,
  input  logic              cyc_start_i,
  input  logic              cyc_end_i,
  input  logic              cyc_cpu_i,
  input  logic              cyc_super_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cs_no,
  output logic              avec_o
);

  cs_opt_t opt;
  logic    busy;
  logic    hit;
  logic    avec_req;

  cs_opt_reg u_opt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (opt_wr_i),
    .wdata_i (cs_opt_t'(opt_wdata_i)),
    .busy_i  (busy),
    .opt_o   (opt)
  );

  cs_match #(.ADDR_W(ADDR_W)) u_match (
    .opt_i      (opt),
    .cpu_i      (cyc_cpu_i),
    .super_i    (cyc_super_i),
    .addr_i     (addr_i),
    .hit_o      (hit),
    .avec_req_o (avec_req)
  );

  cs_strobe_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (cyc_start_i),
    .end_i      (cyc_end_i),
    .hit_i      (hit),
    .avec_req_i (avec_req),
    .cs_no      (cs_no),
    .avec_o     (avec_o),
    .busy_o     (busy)
  );

  assert_disabled_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no) || avec_o) |-> $past(opt.en));

  assert_avec_cpu_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avec_o |-> ($past(opt.space) == SP_CPU));

  assert_avec_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avec_o |-> $past(opt.avec_en));

  assert_level_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no) && ($past(opt.space) == SP_CPU) && ($past(opt.lvl) != '0))
      |-> ($past(addr_i[LVL_LSB +: LVL_W]) == $past(opt.lvl)));

endmodule

// File: tb/cs_iack_matcher_tb.sv
module cs_iack_matcher_tb;

  localparam int ADDR_W = 24;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              opt_wr;
  logic [6:0]        opt_wdata;
  logic              cyc_start, cyc_end, cyc_cpu, cyc_super;
  logic [ADDR_W-1:0] addr;
  logic              cs_no, avec;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cs_iack_matcher #(.ADDR_W(ADDR_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .opt_wr_i    (opt_wr),
    .opt_wdata_i (opt_wdata),
    .cyc_start_i (cyc_start),
    .cyc_end_i   (cyc_end),
    .cyc_cpu_i   (cyc_cpu),
    .cyc_super_i (cyc_super),
    .addr_i      (addr),
    .cs_no       (cs_no),
    .avec_o      (avec)
  );

  // fields: [18:15] req, [14:8] opt, [7] cpu, [6] super, [5:2] addr[3:0], [1] strobe, [0] avec
  localparam int NV = 21;
  localparam logic [18:0] VEC [NV] = '{
    {4'd2,  7'h50, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0},  // R2 user hit
    {4'd2,  7'h50, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0},  // R2 supervisor rejected
    {4'd2,  7'h50, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0},  // R2 cpu cycle rejected
    {4'd3,  7'h60, 1'b0, 1'b1, 4'h0, 1'b1, 1'b0},  // R3
    {4'd3,  7'h60, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0},  // R3
    {4'd3,  7'h60, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0},  // R3
    {4'd4,  7'h70, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0},  // R4
    {4'd4,  7'h70, 1'b0, 1'b1, 4'h0, 1'b1, 1'b0},  // R4
    {4'd4,  7'h70, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0},  // R4
    {4'd5,  7'h4A, 1'b1, 1'b0, 4'hA, 1'b1, 1'b0},  // R5 level 5
    {4'd5,  7'h4A, 1'b1, 1'b1, 4'hB, 1'b1, 1'b0},  // R5 addr[0] ignored
    {4'd5,  7'h4A, 1'b1, 1'b0, 4'h6, 1'b0, 1'b0},  // R5 level 3 rejected
    {4'd5,  7'h4A, 1'b0, 1'b1, 4'hA, 1'b0, 1'b0},  // R5 non-cpu rejected
    {4'd6,  7'h41, 1'b1, 1'b0, 4'hE, 1'b1, 1'b1},  // R6 level 7
    {4'd6,  7'h41, 1'b1, 1'b0, 4'h2, 1'b1, 1'b1},  // R6 level 1
    {4'd8,  7'h47, 1'b1, 1'b0, 4'h6, 1'b1, 1'b1},  // R8
    {4'd8,  7'h47, 1'b1, 1'b0, 4'h8, 1'b0, 1'b0},  // R8 miss, no pulse
    {4'd9,  7'h4A, 1'b1, 1'b0, 4'hA, 1'b1, 1'b0},  // R9
    {4'd10, 7'h51, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0},  // R10
    {4'd10, 7'h71, 1'b0, 1'b1, 4'h0, 1'b1, 1'b0},  // R10
    {4'd11, 7'h01, 1'b1, 1'b0, 4'h2, 1'b0, 1'b0}   // R11
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic write_opt(input logic [6:0] v);
    opt_wr    = 1'b1;
    opt_wdata = v;
    @(negedge clk);
    opt_wr    = 1'b0;
  endtask

  // start at this falling edge, end after two strobe clocks
  task automatic run_cycle(input logic cpu, input logic sup, input logic [3:0] a,
                           output logic cs1, output logic av1,
                           output logic cs2, output logic av2, output logic cs3);
    cyc_start = 1'b1;
    cyc_cpu   = cpu;
    cyc_super = sup;
    addr      = {{(ADDR_W-4){1'b0}}, a};
    @(negedge clk);
    cyc_start = 1'b0;
    cs1 = cs_no; av1 = avec;
    @(negedge clk);
    cs2 = cs_no; av2 = avec;
    cyc_end = 1'b1;
    @(negedge clk);
    cyc_end = 1'b0;
    cs3 = cs_no;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic c1, a1, c2, a2, c3;
    string t;
    rst_ni = 1'b0; opt_wr = 1'b0; opt_wdata = '0;
    cyc_start = 1'b0; cyc_end = 1'b0; cyc_cpu = 1'b0; cyc_super = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R13 reset state and cleared options
    check("R13 cs_no", cs_no, 1'b1);
    check("R13 avec", avec, 1'b0);
    run_cycle(1'b1, 1'b0, 4'h2, c1, a1, c2, a2, c3);
    check("R13 disabled after reset", c1, 1'b1);
    check("R13 no avec", a1, 1'b0);
    run_cycle(1'b0, 1'b1, 4'h0, c1, a1, c2, a2, c3);
    check("R13 disabled supervisor", c1, 1'b1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      t = $sformatf("R%0d vec%0d", VEC[i][18:15], i);
      write_opt(VEC[i][14:8]);
      run_cycle(VEC[i][7], VEC[i][6], VEC[i][5:2], c1, a1, c2, a2, c3);
      check({t, " strobe"}, c1, !VEC[i][1]);
      check({t, " avec"}, a1, VEC[i][0]);
      check({t, " strobe held"}, c2, !VEC[i][1]);
      check({t, " avec one clock"}, a2, 1'b0);
      check({t, " release"}, c3, 1'b1);
      @(negedge clk);
    end

    // R1 idle write used by a cycle on the very next edge
    write_opt(7'h60);
    write_opt(7'h41);
    run_cycle(1'b1, 1'b0, 4'h4, c1, a1, c2, a2, c3);
    check("R1 next-edge effect", c1, 1'b0);
    check("R1 avec", a1, 1'b1);
    @(negedge clk);

    // R7 nested start ignored, strobe held until end
    write_opt(7'h47);
    cyc_start = 1'b1; cyc_cpu = 1'b1; cyc_super = 1'b0; addr = 24'h6;
    @(negedge clk);
    check("R7 strobe after start", cs_no, 1'b0);
    check("R8 pulse", avec, 1'b1);
    cyc_start = 1'b1; addr = 24'h2;
    @(negedge clk);
    cyc_start = 1'b0;
    check("R7 nested start keeps strobe", cs_no, 1'b0);
    check("R7 nested start no repulse", avec, 1'b0);
    repeat (2) @(negedge clk);
    check("R7 held without end", cs_no, 1'b0);
    cyc_end = 1'b1;
    @(negedge clk);
    cyc_end = 1'b0;
    check("R7 released", cs_no, 1'b1);
    check("R7 no avec after end", avec, 1'b0);
    @(negedge clk);

    // R12 writes held during a cycle, last one wins
    write_opt(7'h41);
    cyc_start = 1'b1; cyc_cpu = 1'b1; cyc_super = 1'b0; addr = 24'h2;
    @(negedge clk);
    cyc_start = 1'b0;
    check("R12 first cycle strobe", cs_no, 1'b0);
    write_opt(7'h01);
    write_opt(7'h50);
    check("R12 strobe unaffected by held write", cs_no, 1'b0);
    cyc_end = 1'b1;
    @(negedge clk);
    cyc_end = 1'b0;
    check("R12 release", cs_no, 1'b1);
    run_cycle(1'b1, 1'b0, 4'h2, c1, a1, c2, a2, c3);
    check("R12 release-edge cycle uses old options", c1, 1'b0);
    check("R12 release-edge cycle old avec", a1, 1'b1);
    @(negedge clk);
    run_cycle(1'b1, 1'b0, 4'h2, c1, a1, c2, a2, c3);
    check("R12 new options reject cpu", c1, 1'b1);
    @(negedge clk);
    run_cycle(1'b0, 1'b0, 4'h0, c1, a1, c2, a2, c3);
    check("R12 last write wins", c1, 1'b0);
    check("R12 no avec in user space", a1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule